// File: doc/BRIEF.md
# Staged-Write Receive Address Table

This block holds a small table of unicast receive MAC addresses that a host programs through a 32-bit register port. An entry has 48 address bits and 5 control bits. It is built up over three register writes. The host first selects a table slot in the index register. It then loads the upper 32 address bits into a holding register. Last, it writes the lower 16 address bits together with the control bits. Only that last write changes the table. On that cycle the slot named by the current index receives the assembled 53-bit entry, which combines the held upper bits with the fresh low word. The group (multicast) bit, address bit 40, is always forced to zero, so only unicast addresses can be stored.

Frame-matching logic reads the table through a lookup port. A lookup request carries an entry index and is accepted on every cycle, so the port applies no back-pressure. The response is marked valid exactly one cycle later and carries the stored entry. The match logic must also wait for a ready flag. This flag rises once every slot has been committed at least once since reset, and it then stays high.

Top module: `rx_addr_table`

## Requirements
- R1: After reset the index register and the high register read 0, every table entry reads 0 through the lookup port, and `table_ready` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata[IDX_W-1:0]` as the table index. The index register reads back those bits, and all bits above them read as 0.
- R3: A write with `reg_sel`=1 stores the high register. Byte 2 of the address sits in bits 31:24, byte 3 in bits 23:16, byte 4 in bits 15:8 and byte 5 in bits 7:0. The register reads back as written, except that bit 0 (address bit 40, the group bit) always reads 0.
- R4: A write with `reg_sel`=2 commits one entry to the indexed slot. The entry is laid out as {ctrl[4:0], addr[47:0]}. The control bits are taken from `reg_wdata[20:16]`, and `addr[15:0]` comes from `reg_wdata[15:0]`. The bytes of `addr[47:16]` come from the high register in the positions given in R3, and `addr[40]` is 0. `reg_wdata[31:21]` is ignored.
- R5: Writes to the index register or the high register change no table entry. An entry changes only on the cycle of a low-register write.
- R6: A lookup request (`lk_valid`=1 with `lk_idx`) is answered on the next cycle with `lk_rsp_valid`=1 and the stored entry on `lk_entry`. On a cycle after no request, `lk_rsp_valid` is 0.
- R7: `table_ready` goes to 1 once every slot has been committed at least once since reset, and then stays at 1 until reset.
- R8: A commit leaves the index and high holding registers unchanged. Later low writes therefore reuse the same held upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 high, 2 low (write only) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational readback of the selected register (low reads 0) |
| lk_valid | input | 1 | Lookup request valid |
| lk_idx | input | IDX_W | Lookup entry index |
| lk_rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| lk_entry | output | 53 | Stored entry {ctrl, addr} |
| table_ready | output | 1 | Every slot committed since reset |

## Verification
The assertions assume that `reg_sel` is never 3 during a write and that the register inputs settle away from the clock edge. The bench follows this by changing every input on the falling edge and using only select codes 0 to 2. The commit check assumes that the index used in a commit comes from the index register as it stood at the moment of the low write. Each scenario of the bench therefore sets the index before the low write and never in the same cycle. Lookups are never issued in the same cycle as a commit to the same slot, so the response ordering around a write is never relied on.

// File: rtl/rat_pkg.sv
package rat_pkg;
  localparam int ADDR_W  = 48;
  localparam int CTRL_W  = 5;
  localparam int ENTRY_W = ADDR_W + CTRL_W;
  localparam int GROUP_BIT = 40;

  localparam logic [1:0] SEL_INDEX = 2'd0;
  localparam logic [1:0] SEL_HIGH  = 2'd1;
  localparam logic [1:0] SEL_LOW   = 2'd2;

  typedef logic [ENTRY_W-1:0] entry_t;
endpackage

// File: rtl/rat_regs.sv
module rat_regs
  import rat_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic [31:0]      hi_q,
  output logic             commit,
  output logic [IDX_W-1:0] commit_idx,
  output entry_t           commit_entry
);
  logic [ADDR_W-1:0] full_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      hi_q  <= '0;
    end else if (reg_wr) begin
      if (reg_sel == SEL_INDEX) idx_q <= reg_wdata[IDX_W-1:0];
      if (reg_sel == SEL_HIGH)  hi_q  <= {reg_wdata[31:1], 1'b0};
    end
  end

  // Byte lanes of the high register map onto address bytes 2..5.
  always_comb begin
    full_addr = {hi_q[7:0], hi_q[15:8], hi_q[23:16], hi_q[31:24], reg_wdata[15:0]};
    full_addr[GROUP_BIT] = 1'b0;
  end

  assign commit       = reg_wr && (reg_sel == SEL_LOW);
  assign commit_idx   = idx_q;
  assign commit_entry = {reg_wdata[16+CTRL_W-1:16], full_addr};

  // R8
  hold_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (idx_q == $past(idx_q)) && (hi_q == $past(hi_q)));
endmodule

// File: rtl/rat_store.sv
module rat_store
  import rat_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  input  logic             lk_valid,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_rsp_valid,
  output entry_t           lk_entry,
  output logic             all_seen
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t           tbl [DEPTH];
  logic [DEPTH-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
      seen_q <= '0;
    end else if (wr_en) begin
      tbl[wr_idx]    <= wr_entry;
      seen_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_rsp_valid <= 1'b0;
      lk_entry     <= '0;
    end else begin
      lk_rsp_valid <= lk_valid;
      if (lk_valid) lk_entry <= tbl[lk_idx];
    end
  end

  assign all_seen = &seen_q;

  // R4
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tbl[$past(wr_idx)] == $past(wr_entry));

  // R6
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid == 1'b1 |=> lk_rsp_valid);

  // R6
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid == 1'b0 |=> !lk_rsp_valid);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_seen |=> all_seen);

  for (genvar g = 0; g < DEPTH; g++) begin : g_hold
    // R5
    entry_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(tbl[g]));
  end
endmodule

// File: rtl/rx_addr_table.sv
module rx_addr_table
  import rat_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                lk_valid,
  input  logic [IDX_W-1:0]    lk_idx,
  output logic                lk_rsp_valid,
  output logic [ENTRY_W-1:0]  lk_entry,
  output logic                table_ready
);
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      hi_q;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  entry_t           commit_entry;

  rat_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .idx_q(idx_q), .hi_q(hi_q), .commit(commit),
    .commit_idx(commit_idx), .commit_entry(commit_entry)
  );

  rat_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_idx(commit_idx),
    .wr_entry(commit_entry), .lk_valid(lk_valid), .lk_idx(lk_idx),
    .lk_rsp_valid(lk_rsp_valid), .lk_entry(lk_entry), .all_seen(table_ready)
  );

  always_comb begin
    case (reg_sel)
      SEL_INDEX: reg_rdata = {{(32-IDX_W){1'b0}}, idx_q};
      SEL_HIGH:  reg_rdata = hi_q;
      default:   reg_rdata = '0;
    endcase
  end

  // R2
  idx_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_INDEX) |-> (reg_rdata[31:IDX_W] == '0));

  // R3
  group_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_HIGH) |-> (reg_rdata[0] == 1'b0));

  // R4
  stored_unicast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rsp_valid |-> (lk_entry[GROUP_BIT] == 1'b0));
endmodule

// File: tb/test_rx_addr_table.sv
module test_rx_addr_table;
  localparam int IDX_W = 3;
  localparam int DEPTH = 1 << IDX_W;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 0;
  logic [IDX_W-1:0] lk_idx = 0;
  logic        lk_rsp_valid;
  logic [52:0] lk_entry;
  logic        table_ready;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [52:0] exp_tbl [DEPTH];
  logic [31:0] exp_hi;

  always #5 clk = ~clk;

  rx_addr_table #(.IDX_W(IDX_W)) i_rx_addr_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_idx(lk_idx), .lk_rsp_valid(lk_rsp_valid), .lk_entry(lk_entry),
    .table_ready(table_ready)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [52:0] mk_entry(logic [31:0] hi, logic [31:0] lo);
    logic [47:0] a;
    a = {hi[7:0], hi[15:8], hi[23:16], hi[31:24], lo[15:0]};
    a[40] = 1'b0;
    return {lo[20:16], a};
  endfunction

  task automatic reg_write(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic reg_read(logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic lookup(int idx, output logic [52:0] e, output logic v);
    @(negedge clk);
    lk_valid = 1; lk_idx = idx[IDX_W-1:0];
    @(negedge clk);
    lk_valid = 0;
    e = lk_entry; v = lk_rsp_valid;
  endtask

  task automatic check_table(string req);
    logic [52:0] e; logic v;
    for (int i = 0; i < DEPTH; i++) begin
      lookup(i, e, v);
      check(req, {11'd0, e}, {11'd0, exp_tbl[i]});
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    reg_read(2'd0, d); check("R1 index", d, 0);
    reg_read(2'd1, d); check("R1 high", d, 0);
    check("R1 ready", table_ready, 0);
    check_table("R1 entry");
  endtask

  task automatic t_index;
    logic [31:0] d;
    reg_write(2'd0, 32'hFFFF_FFFD);
    reg_read(2'd0, d); check("R2 index", d, 32'd5);
  endtask

  task automatic t_high;
    logic [31:0] d;
    reg_write(2'd1, 32'h1234_56FF);
    exp_hi = 32'h1234_56FE;
    reg_read(2'd1, d); check("R3 high", d, exp_hi);
  endtask

  task automatic t_commit;
    logic [31:0] lo;
    lo = 32'hFFFF_ABCD;
    reg_write(2'd2, lo);
    exp_tbl[5] = mk_entry(exp_hi, lo);
    check("R4 formula", {11'd0, exp_tbl[5]}, {11'd0, 5'h1F, 48'hFE5634_12ABCD});
    check_table("R4 entry");
  endtask

  task automatic t_no_effect;
    reg_write(2'd0, 32'd2);
    reg_write(2'd1, 32'hDEAD_BEEF);
    exp_hi = 32'hDEAD_BEEE;
    check_table("R5 entry");
  endtask

  task automatic t_lookup;
    logic [52:0] e; logic v;
    lookup(5, e, v);
    check("R6 rsp valid", v, 1);
    check("R6 rsp data", {11'd0, e}, {11'd0, exp_tbl[5]});
    @(negedge clk);
    check("R6 idle", lk_rsp_valid, 0);
  endtask

  task automatic t_fill;
    logic [31:0] d, lo;
    reg_write(2'd1, 32'hA1B2_C3D5);
    exp_hi = 32'hA1B2_C3D4;
    for (int i = 0; i < DEPTH; i++) begin
      reg_write(2'd0, i);
      lo = 32'hFFE0_0000 | (i << 16) | (32'h1000 * i + 32'h21);
      reg_write(2'd2, lo);
      exp_tbl[i] = mk_entry(exp_hi, lo);
      if (i == DEPTH - 2) check("R7 not yet", table_ready, 0);
    end
    @(negedge clk);
    check("R7 ready", table_ready, 1);
    reg_read(2'd1, d); check("R8 high held", d, exp_hi);
    reg_read(2'd0, d); check("R8 index held", d, DEPTH - 1);
    check_table("R8 entry");
    reg_write(2'd0, 32'd0);
    check("R7 sticky", table_ready, 1);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) exp_tbl[i] = '0;
    exp_hi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_index();
    t_high();
    t_commit();
    t_no_effect();
    t_lookup();
    t_fill();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule